// File: doc/BRIEF.md
# Shared-Adder Eight-Function ALU

This block is a combinational arithmetic and logic unit of parameterised width (16 bits by default). A one-bit group select and a two-bit function select together pick one of eight functions. All eight results leave through a single ripple adder. That adder is built only from three-input majority functions and inverters.

Two small conditioning stages sit in front of the adder, and no result multiplexer follows it. In the arithmetic group, the second operand and the carry-in are reshaped so that the adder forms a sum, a difference, an increment or a decrement. In the logic group, the bitwise result is formed ahead of the adder on its first input. The second input and the carry-in are held at zero, so the adder passes the value through unchanged.

There is no clock and no register anywhere in the block. The outputs follow the inputs after the combinational delay.

Top module: `xalu_core`

## Requirements
- R1: With grp_logic=0 and fn_sel=2'b00, {carry_out,result} equals the (WIDTH+1)-bit sum opa+opb.
- R2: With grp_logic=0 and fn_sel=2'b01, result equals opa-opb modulo 2^WIDTH, and carry_out is 1 exactly when opa>=opb (unsigned).
- R3: With grp_logic=0 and fn_sel=2'b10, result equals opa+1 modulo 2^WIDTH, carry_out is 1 exactly when opa is all ones, and opb has no effect.
- R4: With grp_logic=0 and fn_sel=2'b11, result equals opa-1 modulo 2^WIDTH, carry_out is 1 exactly when opa is non-zero, and opb has no effect.
- R5: With grp_logic=1 and fn_sel=2'b00, result equals opa AND opb.
- R6: With grp_logic=1 and fn_sel=2'b01, result equals opa OR opb.
- R7: With grp_logic=1 and fn_sel=2'b10, result equals opa XOR opb.
- R8: With grp_logic=1 and fn_sel=2'b11, result equals the bitwise inverse of opa, and opb has no effect.
- R9: Whenever grp_logic=1, carry_out is 0.
- R10: The block holds no state. With all inputs at zero, result and carry_out are zero, and any input change reaches the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grp_logic | input | 1 | Group select: 0 picks arithmetic functions, 1 picks bitwise functions |
| fn_sel | input | 2 | Function within the selected group |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Adder carry for arithmetic functions, 0 for bitwise functions |

## Verification
The bench builds two copies of the block. The first uses the default WIDTH of 16. It is driven with directed corner operands (zero, all ones, and both sides of the sign boundary) together with random operands for every function. The second uses WIDTH=4, which is small enough to sweep every combination of group, function and both operands. That sweep reaches every carry chain, including the full-length ripple for increment of all ones, decrement of zero, and subtraction with equal operands.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

    // Arithmetic group function codes (fn_sel when grp_logic = 0)
    typedef enum logic [1:0] {
        ARITH_SUM  = 2'b00,
        ARITH_DIFF = 2'b01,
        ARITH_INC  = 2'b10,
        ARITH_DEC  = 2'b11
    } arith_fn_e;

    // Bitwise group function codes (fn_sel when grp_logic = 1)
    typedef enum logic [1:0] {
        BIT_AND = 2'b00,
        BIT_OR  = 2'b01,
        BIT_XOR = 2'b10,
        BIT_INV = 2'b11
    } logic_fn_e;

    // Three-input majority vote
    function automatic logic maj3(input logic p, input logic q, input logic r);
        return (p & q) | (q & r) | (r & p);
    endfunction

endpackage

// File: rtl/xalu_arith_ext.sv
module xalu_arith_ext
    import xalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       fn_sel,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] opb_cond,
    output logic             cin
);
    always_comb begin
        unique case (arith_fn_e'(fn_sel))
            ARITH_SUM: begin
                opb_cond = opb;
                cin      = 1'b0;
            end
            ARITH_DIFF: begin
                opb_cond = ~opb;
                cin      = 1'b1;
            end
            ARITH_INC: begin
                opb_cond = '0;
                cin      = 1'b1;
            end
            ARITH_DEC: begin
                opb_cond = '1;
                cin      = 1'b0;
            end
            default: begin
                opb_cond = '0;
                cin      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xalu_logic_ext.sv
module xalu_logic_ext
    import xalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       fn_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] opa_cond
);
    always_comb begin
        unique case (logic_fn_e'(fn_sel))
            BIT_AND: opa_cond = opa & opb;
            BIT_OR:  opa_cond = opa | opb;
            BIT_XOR: opa_cond = opa ^ opb;
            BIT_INV: opa_cond = ~opa;
            default: opa_cond = '0;
        endcase
    end
endmodule

// File: rtl/xalu_maj_adder.sv
module xalu_maj_adder
    import xalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    // Each slice: the carry is one majority vote. The sum takes two more votes,
    // built from the inverted incoming and outgoing carries.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic pre;
        assign chain[i+1] = maj3(x[i], y[i], chain[i]);
        assign pre        = maj3(x[i], y[i], ~chain[i]);
        assign sum[i]     = maj3(pre, ~chain[i+1], chain[i]);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/xalu_core.sv
module xalu_core
    import xalu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             grp_logic,
    input  logic [1:0]       fn_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    logic [WIDTH-1:0] b_arith;
    logic             cin_arith;
    logic [WIDTH-1:0] a_logic;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic             add_cout;

    xalu_arith_ext #(.WIDTH(WIDTH)) u_aext (
        .fn_sel   (fn_sel),
        .opb      (opb),
        .opb_cond (b_arith),
        .cin      (cin_arith)
    );

    xalu_logic_ext #(.WIDTH(WIDTH)) u_lext (
        .fn_sel   (fn_sel),
        .opa      (opa),
        .opb      (opb),
        .opa_cond (a_logic)
    );

    // Group steering: bitwise functions zero the second adder input and the carry-in
    always_comb begin
        if (grp_logic) begin
            add_x   = a_logic;
            add_y   = '0;
            add_cin = 1'b0;
        end else begin
            add_x   = opa;
            add_y   = b_arith;
            add_cin = cin_arith;
        end
    end

    xalu_maj_adder #(.WIDTH(WIDTH)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (result),
        .cout (add_cout)
    );

    assign carry_out = add_cout & ~grp_logic;
endmodule

// File: rtl/xalu_checker.sv
module xalu_checker #(
    parameter int WIDTH = 16
) (
    input logic             grp_logic,
    input logic [1:0]       fn_sel,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    localparam logic [WIDTH:0] ONE_EXT = {{WIDTH{1'b0}}, 1'b1};

    logic [WIDTH:0] a_ext;
    logic [WIDTH:0] b_ext;

    assign a_ext = {1'b0, opa};
    assign b_ext = {1'b0, opb};

    always_comb begin
        if (!grp_logic && fn_sel == 2'b00)
            assert_sum_R1: assert ({carry_out, result} == a_ext + b_ext)
                else $error("sum mismatch");
        if (!grp_logic && fn_sel == 2'b01)
            assert_diff_R2: assert (result == opa - opb && carry_out == (opa >= opb))
                else $error("difference mismatch");
        if (!grp_logic && fn_sel == 2'b10)
            assert_inc_R3: assert ({carry_out, result} == a_ext + ONE_EXT)
                else $error("increment mismatch");
        if (!grp_logic && fn_sel == 2'b11)
            assert_dec_R4: assert (result == opa - 1'b1 && carry_out == (opa != '0))
                else $error("decrement mismatch");
        if (grp_logic && fn_sel == 2'b11)
            assert_inv_R8: assert (result == ~opa)
                else $error("inverse mismatch");
        if (grp_logic)
            assert_nocarry_R9: assert (carry_out == 1'b0)
                else $error("carry set in bitwise group");
    end
endmodule

bind xalu_core xalu_checker #(.WIDTH(WIDTH)) u_chk (
    .grp_logic (grp_logic),
    .fn_sel    (fn_sel),
    .opa       (opa),
    .opb       (opb),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sim_xalu_core.sv
module sim_xalu_core;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int WS         = 4;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          m16;
    logic [1:0]    s16;
    logic [W-1:0]  a16, b16, r16;
    logic          c16;

    logic          m4;
    logic [1:0]    s4;
    logic [WS-1:0] a4, b4, r4;
    logic          c4;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    xalu_core #(.WIDTH(W)) u0 (
        .grp_logic(m16), .fn_sel(s16), .opa(a16), .opb(b16),
        .result(r16), .carry_out(c16));

    xalu_core #(.WIDTH(WS)) u1 (
        .grp_logic(m4), .fn_sel(s4), .opa(a4), .opb(b4),
        .result(r4), .carry_out(c4));

    // Expected {carry, result} for a w-bit instance, taken from the requirements
    function automatic logic [32:0] expect_op(int w, logic m, logic [1:0] s,
                                              logic [31:0] a, logic [31:0] b);
        logic [32:0] mask = (33'd1 << w) - 33'd1;
        logic [32:0] aa   = {1'b0, a} & mask;
        logic [32:0] bb   = {1'b0, b} & mask;
        logic [32:0] full;
        logic        cy;
        if (!m) begin
            case (s)
                2'b00:   full = aa + bb;
                2'b01:   full = aa + (~bb & mask) + 33'd1;
                2'b10:   full = aa + 33'd1;
                default: full = aa + mask;
            endcase
            cy = full[w];
        end else begin
            case (s)
                2'b00:   full = aa & bb;
                2'b01:   full = aa | bb;
                2'b10:   full = aa ^ bb;
                default: full = ~aa & mask;
            endcase
            cy = 1'b0;
        end
        return {cy, full[31:0] & mask[31:0]};
    endfunction

    task automatic check16(input logic m, input logic [1:0] s,
                           input logic [W-1:0] a, input logic [W-1:0] b,
                           input string req);
        logic [32:0] e;
        m16 = m; s16 = s; a16 = a; b16 = b;
        #(CLK_PERIOD/2);
        e = expect_op(W, m, s, {16'd0, a}, {16'd0, b});
        checks++;
        if (r16 !== e[W-1:0] || c16 !== e[32]) begin
            errors++;
            $display("FAIL %s m=%0b s=%0b a=%h b=%h actual=%b/%h expected=%b/%h",
                     req, m, s, a, b, c16, r16, e[32], e[W-1:0]);
        end
    endtask

    // R10: no state; all-zero inputs give zero outputs, no clock edge needed
    task automatic t_idle();
        check16(1'b0, 2'b00, '0, '0, "R10");
        check16(1'b1, 2'b11, 16'h00ff, '0, "R10");
        check16(1'b0, 2'b00, '0, '0, "R10");
    endtask

    task automatic t_arith(input logic [1:0] s, input string req);
        logic [W-1:0] corner [4] = '{16'h0000, 16'hffff, 16'h8000, 16'h7fff};
        foreach (corner[i])
            foreach (corner[j])
                check16(1'b0, s, corner[i], corner[j], req);
        for (int k = 0; k < 40; k++)
            check16(1'b0, s, W'($urandom), W'($urandom), req);
    endtask

    task automatic t_logic(input logic [1:0] s, input string req);
        logic [W-1:0] corner [4] = '{16'h0000, 16'hffff, 16'h8000, 16'h7fff};
        foreach (corner[i])
            foreach (corner[j])
                check16(1'b1, s, corner[i], corner[j], req);
        for (int k = 0; k < 40; k++)
            check16(1'b1, s, W'($urandom), W'($urandom), req);
    endtask

    // R3, R4, R8: opb must not affect the output
    task automatic t_b_ignored();
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] a = W'($urandom);
            check16(1'b0, 2'b10, a, '0, "R3");
            check16(1'b0, 2'b10, a, '1, "R3");
            check16(1'b0, 2'b11, a, '0, "R4");
            check16(1'b0, 2'b11, a, 16'h5a5a, "R4");
            check16(1'b1, 2'b11, a, '0, "R8");
            check16(1'b1, 2'b11, a, '1, "R8");
        end
    endtask

    // R9: bitwise group never reports a carry, even with all-ones operands
    task automatic t_no_carry();
        for (int s = 0; s < 4; s++)
            check16(1'b1, 2'(s), '1, '1, "R9");
    endtask

    // R1..R9 on the 4-bit copy: full sweep
    task automatic t_sweep4();
        string tags [8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    logic [32:0] e;
                    m4 = op[2]; s4 = op[1:0]; a4 = WS'(a); b4 = WS'(b);
                    #(CLK_PERIOD/2);
                    e = expect_op(WS, op[2], op[1:0], 32'(a), 32'(b));
                    checks++;
                    if (r4 !== e[WS-1:0] || c4 !== e[32]) begin
                        errors++;
                        $display("FAIL %s w4 op=%0d a=%0d b=%0d actual=%b/%h expected=%b/%h",
                                 tags[op], op, a, b, c4, r4, e[32], e[WS-1:0]);
                    end
                end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m16 = 0; s16 = 0; a16 = 0; b16 = 0;
        m4 = 0; s4 = 0; a4 = 0; b4 = 0;
        t_idle();
        t_arith(2'b00, "R1");
        t_arith(2'b01, "R2");
        t_arith(2'b10, "R3");
        t_arith(2'b11, "R4");
        t_logic(2'b00, "R5");
        t_logic(2'b01, "R6");
        t_logic(2'b10, "R7");
        t_logic(2'b11, "R8");
        t_b_ignored();
        t_no_carry();
        t_sweep4();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule